// File: doc/BRIEF.md
# Auto-Accumulating Result Accumulator

This block holds a 40-bit running sum that sits beside a multiply/divide accelerator. Whenever the accelerator presents a finished result with its valid strobe, the result is zero-extended and added into the sum in the same clock edge. A chain of multiply-accumulate or divide-accumulate steps therefore costs no extra cycles.

A processor reaches the sum through a single byte-wide register port. Loading takes five byte writes, starting with the lowest byte. Reading takes five byte reads, starting with the highest byte. The write position and the read position are kept separately. Register traffic is honoured only while the accelerator's busy flag is low. The whole value is captured on the first read, so the five returned bytes always belong to one value.

Top module: `accel_sum_reg`

## Requirements
- R1: After reset the sum is zero, both byte positions are at their start, and `rd_data` is 0.
- R2: On each clock edge with `res_valid` high, the sum becomes the previous sum plus `res_data` zero-extended, modulo 2^40. This happens whatever the state of `busy`, and the new sum is visible to a read strobe in the next cycle.
- R3: The k-th accepted write (k = 0..4) replaces bits [8k+7:8k] of the sum with `wr_data`. After the fifth accepted write the write position returns to k = 0.
- R4: The k-th accepted read (k = 0..4) returns bits [39-8k:32-8k] of the sum as held in the cycle of the first read of that group. `rd_data` changes on the edge that ends the strobe cycle and holds its value at every other edge.
- R5: Results accumulated after the first read of a group do not change the bytes returned by the rest of that group. The next group returns the updated sum.
- R6: A write or read strobe while `busy` is high is ignored. It does not change the sum, does not move either byte position, and does not change `rd_data`.
- R7: The write position and the read position advance independently. A full read between partial writes returns the partly loaded value and does not move the write position.
- R8: When an accepted write and `res_valid` fall in the same cycle, the addressed byte is replaced first and the result is then added to the merged value.
- R9: A sum that overflows past 2^40 - 1 wraps, keeping the low 40 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Accelerator result strobe |
| res_data | input | RES_W (32) | Accelerator result, unsigned |
| busy | input | 1 | Accelerator busy flag; blocks register access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, registered |

## Verification
A wrong internal state can only be seen through the byte port. A corrupted sum or a misplaced write lane shows up in the very next five-read group. A read position knocked off its start shows up as a wrong first byte, one cycle after the strobe. A write position that has slipped stays hidden until a later read returns a byte in the wrong lane. For that reason the bench reads the sum back after every loading pattern, after every accumulation batch, and after every stretch of ignored traffic, so that any such fault is seen within at most ten register cycles.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int unsigned LANE_W = 8;

   function automatic int unsigned lane_count(input int unsigned total_w);
      return total_w / LANE_W;
   endfunction
endpackage

// File: rtl/acc_byte_seq.sv
module acc_byte_seq #(
   parameter int unsigned COUNT = 5,
   localparam int unsigned PW = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [PW-1:0] ptr
);
   localparam logic [PW-1:0] LAST = PW'(COUNT - 1);

   generate
      if (COUNT < 2) begin : g_bad_count
         $error("acc_byte_seq: COUNT must be at least 2");
      end
   endgenerate

   logic [PW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (step) begin
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/acc_core.sv
module acc_core #(
   parameter int unsigned ACC_W  = 40,
   parameter int unsigned RES_W  = 32,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned NL = ACC_W / LANE_W,
   localparam int unsigned SW = (NL > 1) ? $clog2(NL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add_en,
   input  logic [RES_W-1:0]  add_val,
   input  logic              lane_we,
   input  logic [SW-1:0]     lane_sel,
   input  logic [LANE_W-1:0] lane_data,
   output logic [ACC_W-1:0]  acc
);
   logic [ACC_W-1:0] ext_val;
   logic [ACC_W-1:0] merged;
   logic [ACC_W-1:0] acc_d;
   logic [ACC_W-1:0] acc_q;

   generate
      if (RES_W == ACC_W) begin : g_ext_full
         assign ext_val = add_val;
      end else begin : g_ext_zero
         assign ext_val = {{(ACC_W - RES_W){1'b0}}, add_val};
      end
   endgenerate

   generate
      for (genvar g = 0; g < NL; g++) begin : g_lane
         assign merged[g*LANE_W +: LANE_W] =
            (lane_we && (lane_sel == SW'(g))) ? lane_data : acc_q[g*LANE_W +: LANE_W];
      end
   endgenerate

   always_comb begin
      acc_d = merged;
      if (add_en) begin
         acc_d = merged + ext_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else begin
         acc_q <= acc_d;
      end
   end

   assign acc = acc_q;
endmodule

// File: rtl/acc_read_snap.sv
module acc_read_snap #(
   parameter int unsigned ACC_W  = 40,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned NL = ACC_W / LANE_W,
   localparam int unsigned SW = (NL > 1) ? $clog2(NL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [SW-1:0]     rd_sel,
   input  logic [ACC_W-1:0]  live,
   output logic [LANE_W-1:0] rd_data
);
   logic [ACC_W-1:0]  snap_q;
   logic [LANE_W-1:0] snap_lane [NL];
   logic [SW-1:0]     rev_sel;
   logic              first;
   logic [LANE_W-1:0] rd_q;

   generate
      for (genvar g = 0; g < NL; g++) begin : g_lane
         assign snap_lane[g] = snap_q[g*LANE_W +: LANE_W];
      end
   endgenerate

   assign first   = (rd_sel == '0);
   assign rev_sel = SW'(NL - 1) - rd_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         rd_q   <= '0;
      end else if (rd_en) begin
         if (first) begin
            snap_q <= live;
            rd_q   <= live[ACC_W-1 -: LANE_W];
         end else begin
            rd_q   <= snap_lane[rev_sel];
         end
      end
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/accel_sum_reg.sv
module accel_sum_reg #(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned RES_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   input  logic [RES_W-1:0] res_data,
   input  logic             busy,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data
);
   import acc_pkg::*;

   localparam int unsigned NL = lane_count(ACC_W);
   localparam int unsigned SW = (NL > 1) ? $clog2(NL) : 1;

   generate
      if ((ACC_W % LANE_W) != 0) begin : g_bad_width
         $error("accel_sum_reg: ACC_W must be a multiple of the lane width");
      end
      if (RES_W > ACC_W || RES_W == 0) begin : g_bad_res
         $error("accel_sum_reg: RES_W must be between 1 and ACC_W");
      end
      if (NL < 2) begin : g_bad_lanes
         $error("accel_sum_reg: at least two lanes required");
      end
   endgenerate

   logic             wr_ok;
   logic             rd_ok;
   logic [SW-1:0]    wr_ptr;
   logic [SW-1:0]    rd_ptr;
   logic [ACC_W-1:0] acc_q;

   assign wr_ok = reg_wr & ~busy;
   assign rd_ok = reg_rd & ~busy;

   acc_byte_seq #(.COUNT(NL)) u_wr_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (wr_ok),
      .ptr   (wr_ptr)
   );

   acc_byte_seq #(.COUNT(NL)) u_rd_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (rd_ok),
      .ptr   (rd_ptr)
   );

   acc_core #(.ACC_W(ACC_W), .RES_W(RES_W), .LANE_W(LANE_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .add_en    (res_valid),
      .add_val   (res_data),
      .lane_we   (wr_ok),
      .lane_sel  (wr_ptr),
      .lane_data (wr_data),
      .acc       (acc_q)
   );

   acc_read_snap #(.ACC_W(ACC_W), .LANE_W(LANE_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_ok),
      .rd_sel  (rd_ptr),
      .live    (acc_q),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/acc_checker.sv
module acc_checker #(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned RES_W = 32,
   localparam int unsigned NL = ACC_W / 8,
   localparam int unsigned SW = (NL > 1) ? $clog2(NL) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             res_valid,
   input logic [RES_W-1:0] res_data,
   input logic             busy,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [7:0]       rd_data,
   input logic [ACC_W-1:0] acc_q,
   input logic [SW-1:0]    wr_ptr,
   input logic [SW-1:0]    rd_ptr
);
   // R2 and R9: pure accumulation wraps modulo 2^ACC_W
   a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !(reg_wr && !busy)) |=> acc_q == $past(acc_q) + ACC_W'($past(res_data)));

   // R6: busy blocks every register effect
   a_r6_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !res_valid) |=> ($stable(acc_q) && $stable(wr_ptr) && $stable(rd_ptr) && $stable(rd_data)));

   // R3 and R4: positions stay within the lane count
   a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr < SW'(NL)) && (rd_ptr < SW'(NL)));

   // R3: accepted write advances and wraps the write position
   a_r3_wr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !busy) |=> wr_ptr == (($past(wr_ptr) == SW'(NL - 1)) ? '0 : $past(wr_ptr) + 1'b1));

   // R4: first read of a group returns the top byte of the live sum
   a_r4_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !busy && rd_ptr == '0) |=> rd_data == $past(acc_q[ACC_W-1 -: 8]));

   // R4: read data holds without an accepted read
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rd || busy) |=> $stable(rd_data));

   // R7: a read never moves the write position
   a_r7_independent: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(wr_ptr));
endmodule

bind accel_sum_reg acc_checker #(.ACC_W(ACC_W), .RES_W(RES_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .res_valid (res_valid),
   .res_data  (res_data),
   .busy      (busy),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .rd_data   (rd_data),
   .acc_q     (acc_q),
   .wr_ptr    (wr_ptr),
   .rd_ptr    (rd_ptr)
);

// File: tb/sim_accel_sum_reg.sv
module sim_accel_sum_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [31:0] res_data = '0;
   logic        busy = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model, from the requirements
   logic [39:0] m_acc = '0;
   logic [39:0] m_snap = '0;
   logic [7:0]  m_rd = '0;
   int          m_w = 0;
   int          m_r = 0;

   always #5 clk = ~clk;

   accel_sum_reg u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res_data  (res_data),
      .busy      (busy),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .wr_data   (wr_data),
      .rd_data   (rd_data)
   );

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic [7:0] wd, input logic r,
                       input logic v, input logic [31:0] rv, input logic b);
      logic [39:0] nxt;
      reg_wr = w; wr_data = wd; reg_rd = r; res_valid = v; res_data = rv; busy = b;
      if (r && !b) begin
         if (m_r == 0) m_snap = m_acc;
         m_rd = m_snap[8*(4-m_r) +: 8];
         m_r = (m_r + 1) % 5;
      end
      nxt = m_acc;
      if (w && !b) begin
         nxt[8*m_w +: 8] = wd;
         m_w = (m_w + 1) % 5;
      end
      if (v) nxt = nxt + {8'h00, rv};
      m_acc = nxt;
      @(posedge clk);
      #1;
      reg_wr = 1'b0; reg_rd = 1'b0; res_valid = 1'b0; busy = 1'b0;
   endtask

   task automatic read_byte(input string req);
      step(1'b0, 8'h00, 1'b1, 1'b0, 32'h0, 1'b0);
      check(req, {32'h0, rd_data}, {32'h0, m_rd});
   endtask

   task automatic read_all(input string req);
      for (int k = 0; k < 5; k++) read_byte(req);
   endtask

   task automatic load(input logic [39:0] val);
      for (int k = 0; k < 5; k++) step(1'b1, val[8*k +: 8], 1'b0, 1'b0, 32'h0, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lcg;
      logic [7:0]  held;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;

      // R1: reset state
      check("R1 rd_data", {32'h0, rd_data}, 40'h0);
      read_all("R1 zero sum");

      // R3/R4: loading patterns read back
      load(40'h01_23_45_67_89); read_all("R3 load/R4 read");
      load(40'hFF_FF_FF_FF_FF); read_all("R3 load/R4 read");
      load(40'h80_00_00_00_01); read_all("R3 load/R4 read");
      for (int s = 0; s < 40; s += 7) begin
         load(40'h1 << s); read_all("R3 walking one");
      end
      check("R3 model", m_acc, 40'h1 << 35);

      // R2: accumulation, some with busy high
      load(40'h0);
      lcg = 32'h1234_5678;
      for (int n = 0; n < 60; n++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         step(1'b0, 8'h00, 1'b0, 1'b1, lcg, n[0]);
         if (n % 10 == 9) read_all("R2 accumulate");
      end
      // back-to-back result then immediate read
      load(40'h0);
      step(1'b0, 8'h00, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0);
      read_all("R2 next-cycle visibility");
      check("R2 value", m_acc, 40'h00_DEAD_BEEF);

      // R9: wrap
      load(40'hFF_FF_FF_FF_F0);
      step(1'b0, 8'h00, 1'b0, 1'b1, 32'h0000_0020, 1'b0);
      read_all("R9 wrap");
      check("R9 value", m_acc, 40'h00_00_00_00_10);
      load(40'hFF_FF_FF_FF_FF);
      step(1'b0, 8'h00, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
      read_all("R9 wrap max");

      // R6: busy-blocked traffic
      load(40'hA5_5A_C3_3C_96);
      read_byte("R6 pre");
      held = rd_data;
      for (int n = 0; n < 6; n++) step(1'b1, 8'hEE, 1'b1, 1'b0, 32'h0, 1'b1);
      check("R6 rd_data hold", {32'h0, rd_data}, {32'h0, held});
      for (int k = 1; k < 5; k++) read_byte("R6 read position kept");
      read_all("R6 sum kept");
      load(40'h11_22_33_44_55);
      read_all("R6 write position kept");

      // R5: snapshot on first read
      load(40'h00_00_00_10_00);
      read_byte("R5 first");
      step(1'b0, 8'h00, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b1, 32'h0000_1234, 1'b0);
      for (int k = 1; k < 5; k++) read_byte("R5 snapshot");
      read_all("R5 next group updated");

      // R7: independent positions
      load(40'h0);
      step(1'b1, 8'hAB, 1'b0, 1'b0, 32'h0, 1'b0);
      step(1'b1, 8'hCD, 1'b0, 1'b0, 32'h0, 1'b0);
      read_all("R7 partial load");
      step(1'b1, 8'h01, 1'b0, 1'b0, 32'h0, 1'b0);
      step(1'b1, 8'h02, 1'b1, 1'b0, 32'h0, 1'b0);
      check("R7 read during write", {32'h0, rd_data}, {32'h0, m_rd});
      step(1'b1, 8'h03, 1'b0, 1'b0, 32'h0, 1'b0);
      for (int k = 1; k < 5; k++) read_byte("R7 interleave");
      read_all("R7 full");
      check("R7 value", m_acc, 40'h03_02_01_CD_AB);

      // R8: write and result together
      load(40'h00_00_00_00_00);
      step(1'b1, 8'hF0, 1'b0, 1'b1, 32'h0000_0020, 1'b0);
      check("R8 model", m_acc, 40'h00_00_00_01_10);
      read_all("R8 merge then add");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule